// File: doc/BRIEF.md
# Matrix Keyboard Scanner

This block walks a key matrix of up to eight rows by eight columns. It drives one scan position at a time on four scan lines and samples eight active-low return lines near the end of each position. A closure that stays put across two passes of the scan is debounced and encoded as a key byte. The key byte carries the row and column of the key together with the shift and control inputs, and goes into an eight-entry queue.

A host sees two byte-wide registers, chosen by one address bit:

- **Data register** (address bit 0): a read returns the oldest key byte and removes it from the queue.
- **Control/status register** (address bit 1): a write carries a mode word, and a read returns a status byte.

An interrupt line stays high while the queue holds at least one key.

The scan lines run in one of two ways:

- **Binary count:** the position number is driven high-true, stepping through 8 positions, or 16 when the wide option is set.
- **Single-low pattern:** exactly one of the four lines is low at a time.

Only positions 0 to 7 carry key rows. In the single-low pattern the row is the index of the low line.

Top module: `keypad_scanner`

## Requirements
- R1: A byte written with `bus_a0`=1 whose bits 7:5 are 000 loads the mode. Bit 0 set selects the single-low scan pattern. Bit 3 set selects 16 binary positions instead of 8. The same write restarts the scan at position 0 in its first cycle. A control write with any other value in bits 7:5 leaves the mode and the scan untouched.
- R2: In binary mode `scan_out` equals the position number, each position lasting `DWELL_CYCLES` clocks. The count wraps after 7, or after 15 in wide mode.
- R3: In single-low mode `scan_out` steps 1110, 1101, 1011, 0111 and repeats, each pattern lasting `DWELL_CYCLES` clocks.
- R4: A low return line `ret_n[c]` while row r is scanned is a closure of key (r,c). The returns are sampled in the last dwell cycle of each key position. Positions 8 to 15 carry no keys.
- R5: A closure seen on two consecutive samples of its row is queued once. It is not queued again while it stays closed, and it may be queued again after a sample sees it open. A closure present at only one sample is never queued.
- R6: A key byte is {ctrl_in, shift_in, r*8+c}: bit 7 is ctrl, bit 6 is shift, and bits 5:0 are the code. When several new closures appear in one row, the lowest column is queued first, one per pass of the scan.
- R7: The queue holds 8 key bytes in arrival order. A read with `bus_a0`=0 returns the oldest byte and removes it. A read of an empty queue returns 0x00.
- R8: A read with `bus_a0`=1 returns the status byte: bits 2:0 are the entry count modulo 8, bit 3 is full, bit 5 is overrun, and all other bits are 0.
- R9: A key that is due while the queue is full is discarded and sets overrun. A status read clears overrun; a new overrun in the same cycle wins.
- R10: `irq` is high exactly while the queue is not empty.
- R11: After reset the mode is binary with 8 positions, `scan_out` is 0, the queue is empty, overrun is clear and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_a0 | input | 1 | Register select: 0 selects data, 1 selects control/status |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle `bus_rd` is high |
| irq | output | 1 | Key available |
| scan_out | output | 4 | Scan lines |
| ret_n | input | 8 | Return lines, active low |
| shift_in | input | 1 | Shift level, sampled with the returns |
| ctrl_in | input | 1 | Control level, sampled with the returns |

## Verification
The assertions assume that the return lines, shift and control are synchronous to `clk`, so a sample never catches a line in the middle of a change. They also assume the host never raises read and write in the same cycle. The bench meets both assumptions by deriving the return lines combinationally from `scan_out` and its own key map, and by changing keys and bus strobes only at falling edges, one access at a time. Mode words are written only while no key is held, so a restart never cuts a debounce window in two.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int KBD_ROWS   = 8;
  localparam int KBD_COLS   = 8;
  localparam int ROW_W      = $clog2(KBD_ROWS);
  localparam int COL_W      = $clog2(KBD_COLS);
  localparam int CODE_W     = ROW_W + COL_W;
  localparam int SCAN_LINES = 4;
  localparam int MAX_POS    = 16;
  localparam int POS_W      = $clog2(MAX_POS);
  localparam logic [2:0] OPC_MODE = 3'b000;

  typedef struct packed {
    logic              ctrl;
    logic              shift;
    logic [CODE_W-1:0] code;
  } key_entry_t;

  typedef struct packed {
    logic wide;     // 16 binary positions
    logic decoded;  // single-low pattern on four lines
  } scan_mode_t;
endpackage

// File: rtl/scan_seq.sv
module scan_seq
  import kbd_pkg::*;
#(
  parameter int DWELL_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  scan_mode_t            mode,
  input  logic                  restart,
  output logic [SCAN_LINES-1:0] scan_out,
  output logic                  sample,
  output logic [ROW_W-1:0]      row
);
  localparam int DCW = $clog2(DWELL_CYCLES + 1);
  localparam logic [DCW-1:0]   DW_LAST   = DCW'(DWELL_CYCLES - 1);
  localparam logic [POS_W-1:0] KEY_LIMIT = POS_W'(KBD_ROWS);

  logic [POS_W-1:0] pos_q;
  logic [DCW-1:0]   dw_q;
  logic [POS_W-1:0] last_pos;

  always_comb begin
    if (mode.decoded)   last_pos = POS_W'(SCAN_LINES - 1);
    else if (mode.wide) last_pos = POS_W'(MAX_POS - 1);
    else                last_pos = POS_W'(KBD_ROWS - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      dw_q  <= '0;
    end else if (restart) begin
      pos_q <= '0;
      dw_q  <= '0;
    end else if (dw_q == DW_LAST) begin
      dw_q  <= '0;
      pos_q <= (pos_q == last_pos) ? '0 : pos_q + 1'b1;
    end else begin
      dw_q <= dw_q + 1'b1;
    end
  end

  generate
    if (SCAN_LINES == 4) begin : g_four_lines
      always_comb begin
        if (mode.decoded) scan_out = ~(SCAN_LINES'(1) << pos_q[1:0]);
        else              scan_out = pos_q;
      end
    end else begin : g_other_lines
      always_comb scan_out = SCAN_LINES'(pos_q);
    end
  endgenerate

  assign sample = (dw_q == DW_LAST) && (pos_q < KEY_LIMIT);
  assign row    = pos_q[ROW_W-1:0];
endmodule

// File: rtl/key_debounce.sv
module key_debounce
  import kbd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample,
  input  logic [ROW_W-1:0]    row,
  input  logic [KBD_COLS-1:0] ret_n,
  input  logic                shift_in,
  input  logic                ctrl_in,
  output logic                key_valid,
  output key_entry_t          key_entry
);
  logic [KBD_COLS-1:0] prev_q [KBD_ROWS];
  logic [KBD_COLS-1:0] done_q [KBD_ROWS];
  logic [KBD_COLS-1:0] closed, fresh, pick;
  logic [COL_W-1:0]    col;

  function automatic logic [COL_W-1:0] low_index(input logic [KBD_COLS-1:0] v);
    logic [COL_W-1:0] idx;
    idx = '0;
    for (int c = KBD_COLS - 1; c >= 0; c--)
      if (v[c]) idx = COL_W'(c);
    return idx;
  endfunction

  assign closed = ~ret_n;
  assign fresh  = closed & prev_q[row] & ~done_q[row];
  assign pick   = fresh & (~fresh + 1'b1);
  assign col    = low_index(fresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < KBD_ROWS; r++) begin
        prev_q[r] <= '0;
        done_q[r] <= '0;
      end
      key_valid <= 1'b0;
      key_entry <= '0;
    end else begin
      key_valid <= 1'b0;
      if (sample) begin
        prev_q[row] <= closed;
        done_q[row] <= (done_q[row] & closed) | pick;
        if (|fresh) begin
          key_valid       <= 1'b1;
          key_entry.ctrl  <= ctrl_in;
          key_entry.shift <= shift_in;
          key_entry.code  <= {row, col};
        end
      end
    end
  end

  // R5: a queued key always follows a return sample
  a_r5_push_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> $past(sample));
endmodule

// File: rtl/key_fifo.sv
module key_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [WIDTH-1:0]           wdata,
  input  logic                       pop,
  output logic [WIDTH-1:0]           head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (count == CNT_MAX);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: occupancy never exceeds the depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_MAX);
  // R9: a push into a full queue without a pop leaves the occupancy alone
  a_r9_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(count));
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import kbd_pkg::*;
#(
  parameter int DWELL_CYCLES = 4,
  parameter int FIFO_DEPTH   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_a0,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic [3:0] scan_out,
  input  logic [7:0] ret_n,
  input  logic       shift_in,
  input  logic       ctrl_in
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int LOW_W = (CNT_W > 1) ? CNT_W - 1 : 1;

  scan_mode_t       mode_q;
  logic             mode_wr, sample, key_valid, fifo_full, fifo_empty, fifo_pop;
  logic             ovr_q;
  logic [ROW_W-1:0] row;
  key_entry_t       key_entry;
  logic [7:0]       fifo_head;
  logic [CNT_W-1:0] fifo_count;
  logic [2:0]       cnt_field;
  logic             unused_mode_bits;

  assign mode_wr          = bus_wr && bus_a0 && (bus_wdata[7:5] == OPC_MODE);
  assign unused_mode_bits = ^{bus_wdata[4], bus_wdata[2:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_wr) mode_q <= '{wide: bus_wdata[3], decoded: bus_wdata[0]};
  end

  scan_seq #(.DWELL_CYCLES(DWELL_CYCLES)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .restart  (mode_wr),
    .scan_out (scan_out),
    .sample   (sample),
    .row      (row)
  );

  key_debounce u_deb (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample    (sample),
    .row       (row),
    .ret_n     (ret_n),
    .shift_in  (shift_in),
    .ctrl_in   (ctrl_in),
    .key_valid (key_valid),
    .key_entry (key_entry)
  );

  assign fifo_pop = bus_rd && !bus_a0 && !fifo_empty;

  key_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (key_valid),
    .wdata (key_entry),
    .pop   (fifo_pop),
    .head  (fifo_head),
    .count (fifo_count),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ovr_q <= 1'b0;
    else if (key_valid && fifo_full) ovr_q <= 1'b1;
    else if (bus_rd && bus_a0)     ovr_q <= 1'b0;
  end

  assign cnt_field = 3'(fifo_count[LOW_W-1:0]);
  assign irq       = !fifo_empty;

  always_comb begin
    if (bus_a0)          bus_rdata = {2'b00, ovr_q, 1'b0, fifo_full, cnt_field};
    else if (fifo_empty) bus_rdata = 8'h00;
    else                 bus_rdata = fifo_head;
  end

  // R9: overrun only rises after a key met a full queue
  a_r9_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(key_valid && fifo_full));
  // R2: narrow binary mode stays inside the eight key positions
  a_r2_encoded_range: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q.decoded && !mode_q.wide) |-> (scan_out < 4'd8));
  // R3: single-low mode drives exactly one low line
  a_r3_one_low: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.decoded |-> ($countones(scan_out) == 3));
  // R10: the interrupt drops only when the last key is read
  a_r10_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_rd && !bus_a0));
endmodule

// File: tb/keypad_scanner_tb.sv
module keypad_scanner_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DWELL      = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_a0 = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;
  logic [3:0] scan_out;
  logic [7:0] ret_n;
  logic       shift_in = 1'b0, ctrl_in = 1'b0;

  logic [63:0] pressed_map = '0;
  logic        tb_decoded = 1'b0;
  int          scan_len = 8 * DWELL;
  int          n_checks = 0, n_errors = 0;
  logic [7:0]  exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  keypad_scanner #(.DWELL_CYCLES(DWELL)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_a0(bus_a0), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .scan_out(scan_out),
    .ret_n(ret_n), .shift_in(shift_in), .ctrl_in(ctrl_in)
  );

  // key matrix model: returns follow the scanned row
  logic       row_ok;
  logic [2:0] row_idx;
  always_comb begin
    row_ok  = 1'b0;
    row_idx = 3'd0;
    if (tb_decoded) begin
      for (int i = 0; i < 4; i++)
        if (scan_out == ~(4'b0001 << i)) begin row_ok = 1'b1; row_idx = 3'(i); end
    end else if (scan_out < 4'd8) begin
      row_ok  = 1'b1;
      row_idx = scan_out[2:0];
    end
    ret_n = row_ok ? ~pressed_map[{row_idx, 3'b000} +: 8] : 8'hFF;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a0, input logic [7:0] d);
    @(negedge clk);
    bus_a0 = a0; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a0, output logic [7:0] d);
    @(negedge clk);
    bus_a0 = a0; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // driver: holds keys, records the byte each press should queue
  task automatic press_keys(input logic [63:0] keys, input bit sh, input bit ct,
                            input int hold, input int nexp, input int first_code,
                            input int step);
    shift_in = sh; ctrl_in = ct;
    pressed_map = keys;
    repeat (hold) @(negedge clk);
    pressed_map = '0;
    repeat (3 * scan_len) @(negedge clk);
    shift_in = 1'b0; ctrl_in = 1'b0;
    for (int k = 0; k < nexp; k++)
      exp_q.push_back({ct, sh, 6'(first_code + k * step)});
  endtask

  // monitor: pops the queue and compares each byte read back
  task automatic drain(input string req);
    logic [7:0] d;
    logic [7:0] e;
    int guard = 0;
    while (irq && guard < 16) begin
      bus_read(1'b0, d);
      guard++;
      if (exp_q.size() == 0) check(1'b0, {req, " unexpected key"}, d, 0);
      else begin
        e = exp_q.pop_front();
        check(d == e, req, d, e);
      end
    end
    check(exp_q.size() == 0, {req, " missing keys"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic check_scan(input int npos, input bit dec, input string req);
    logic [3:0] first, prev, expv;
    int guard = 0, bad = 0, bad_act = 0, bad_exp = 0;
    bit hit = 0;
    first = dec ? 4'b1110 : 4'd0;
    prev = scan_out;
    while (!hit && guard < 1000) begin
      @(negedge clk);
      hit = (scan_out == first) && (prev != first);
      prev = scan_out;
      guard++;
    end
    for (int i = 0; i < npos * DWELL; i++) begin
      if (i > 0) @(negedge clk);
      expv = dec ? ~(4'b0001 << (i / DWELL)) : 4'(i / DWELL);
      if (scan_out != expv && bad == 0) begin bad_act = scan_out; bad_exp = expv; end
      if (scan_out != expv) bad++;
    end
    check(hit && bad == 0, req, bad_act, bad_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R11 reset state
    #1 check(scan_out == 4'd0, "R11 scan_out at reset", scan_out, 0);
    check(irq == 1'b0, "R11 irq at reset", irq, 0);
    rst_n = 1'b1;
    bus_read(1'b1, d);
    check(d == 8'h00, "R11/R8 status at reset", d, 0);

    // R2 binary eight-position scan
    check_scan(8, 1'b0, "R2 binary scan sequence");

    // R4 R5 R6 single keys with modifiers
    press_keys(64'd1 << 0, 1'b0, 1'b0, 4 * scan_len, 1, 0, 0);
    press_keys(64'd1 << 63, 1'b1, 1'b0, 4 * scan_len, 1, 63, 0);
    press_keys(64'd1 << 29, 1'b1, 1'b1, 4 * scan_len, 1, 29, 0);
    drain("R6 key byte row*8+col with shift/ctrl");

    // R6 two keys in row 2: column 1 then column 6
    press_keys((64'd1 << 17) | (64'd1 << 22), 1'b0, 1'b0, 5 * scan_len, 2, 17, 5);
    drain("R6 lowest column first");

    // R5 held key queued once
    press_keys(64'd1 << 42, 1'b0, 1'b0, 10 * scan_len, 1, 42, 0);
    drain("R5 held key no repeat");

    // R5 closure present at a single sample only
    press_keys(64'd1 << 11, 1'b0, 1'b0, scan_len, 0, 0, 0);
    bus_read(1'b1, d);
    check(d == 8'h00, "R5 single-sample closure ignored", d, 0);
    check(irq == 1'b0, "R10 irq low with empty queue", irq, 0);

    // R7 R8 R9 R10 fill beyond capacity
    for (int k = 0; k < 9; k++)
      press_keys(64'd1 << (k * 7), 1'b0, 1'b0, 4 * scan_len, (k < 8) ? 1 : 0, k * 7, 0);
    check(irq == 1'b1, "R10 irq high with keys queued", irq, 1);
    bus_read(1'b1, d);
    check(d == 8'h28, "R8/R9 status full with overrun", d, 8'h28);
    bus_read(1'b1, d);
    check(d == 8'h08, "R9 overrun cleared by status read", d, 8'h08);
    drain("R7 queue order after overrun");
    bus_read(1'b0, d);
    check(d == 8'h00, "R7 empty read returns zero", d, 0);
    bus_read(1'b1, d);
    check(d == 8'h00, "R8 status after draining", d, 0);

    // R1 non-mode opcode and data-port write ignored
    bus_write(1'b1, 8'h21);
    bus_write(1'b0, 8'h09);
    check_scan(8, 1'b0, "R1 other opcode leaves mode");

    // R1 R3 single-low mode
    bus_write(1'b1, 8'h01);
    tb_decoded = 1'b1; scan_len = 4 * DWELL;
    #1 check(scan_out == 4'b1110, "R1 restart at first position", scan_out, 4'he);
    check_scan(4, 1'b1, "R3 single-low sequence");
    press_keys(64'd1 << 20, 1'b0, 1'b1, 4 * scan_len, 1, 20, 0);
    drain("R3/R4 key in single-low mode");

    // R1 R2 wide binary mode
    bus_write(1'b1, 8'h08);
    tb_decoded = 1'b0; scan_len = 16 * DWELL;
    check_scan(16, 1'b0, "R2 wide binary sequence");
    press_keys(64'd1 << 51, 1'b0, 1'b0, 4 * scan_len, 1, 51, 0);
    drain("R4 key in wide mode");

    // R1 restart on return to narrow mode
    repeat (2 * DWELL + 1) @(negedge clk);
    bus_write(1'b1, 8'h00);
    scan_len = 8 * DWELL;
    #1 check(scan_out == 4'd0, "R1 restart at position 0", scan_out, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule